// File: doc/BRIEF.md
# NOR Flash Command Sequence Controller

This block is the command front end of a parallel NOR flash model. It watches host write cycles (address, data and a write strobe), recognises interlocked unlock sequences, and runs two kinds of operation without help from the host. The first is a single-word program. The second is a whole-chip erase that clears the array to zeros before it erases it. While an operation runs, reads return a status byte instead of array data. Commands written during a chip erase have no effect. An active-low hardware reset ends whatever is running.

A running program can be put on hold with a suspend command and restarted with a resume command. After the suspend, the block stays busy for a settling delay before it reports that it is suspended. While suspended, reads from the sector being programmed are blocked, and reads from any other sector return array data. The array itself sits outside the block. The block drives the array read address, receives read data, and issues single-cycle pulses for a word write, a fill with zeros and an erase to all ones. The durations of the program, fill, erase and settling phases are parameters given in clock cycles.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: After hardware reset, `busy`, `suspended`, `arr_wr`, `zero_all` and `erase_all` are all 0.
- R2: The six writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h start a chip erase. Only the low 12 address bits are compared. `busy` is 1 from the cycle after the last write. `zero_all` pulses PRE_CYC cycles after the capture edge of that write. `erase_all` pulses ERS_CYC cycles after that, and `busy` drops in the same cycle.
- R3: A write that does not match the next expected step returns the decoder to idle. That write is not reused. A broken sequence starts no operation.
- R4: While a chip erase runs, every write has no effect, including suspend (B0h) and program sequences. The erase completion time stays the same and `suspended` stays 0.
- R5: A read while `busy` returns a status byte. Bit 7 is the complement of the final data: 0 for an erase, the inverse of the data's bit 7 for a program. Bit 6 inverts on every status read. Bit 2 follows bit 6 during an erase and is 0 during a program. Bits 5, 4, 3, 1 and 0 are 0.
- R6: Asserting `rst_n` low aborts a running erase. No `zero_all` or `erase_all` pulse follows, `busy` is 0, and reads return array data.
- R7: The writes AAh@555h, 55h@2AAh, A0h@555h and then a data word at a target address start a program. `arr_wr` pulses PROG_CYC cycles after the data write, with `arr_wa` and `arr_wd` equal to that address and data.
- R8: Writing B0h at any address during a program keeps `busy` high for SUSP_LAT more cycles. After that, `suspended` is 1 and `busy` is 0.
- R9: While suspended, a read whose top SECT_W address bits match the programmed sector returns {~data[7], 7'b0} and not array data. Reads from any other sector return array data.
- R10: While suspended, writing 30h at any address resumes the program, and any other write has no effect. The suspend edge and the resume edge do not count toward the program time, so `arr_wr` fires after the remaining cycles.
- R11: In read mode, a read returns `arr_data` one cycle after `rd_en`, and `arr_ra` follows `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset, aborts any operation |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | 8 | Host write data or command code |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | ADDR_W | Host read address |
| arr_data | input | 8 | Array read data for `arr_ra` |
| rd_data | output | 8 | Read result, valid the cycle after `rd_en` |
| arr_ra | output | ADDR_W | Array read address |
| busy | output | 1 | An operation is running |
| suspended | output | 1 | A program is on hold |
| arr_wr | output | 1 | Single-cycle array word write pulse |
| arr_wa | output | ADDR_W | Address for `arr_wr` |
| arr_wd | output | 8 | Data for `arr_wr` |
| zero_all | output | 1 | Pulse: fill the whole array with zeros |
| erase_all | output | 1 | Pulse: set the whole array to ones |

## Verification
The edge that captures a write counts as cycle zero. `busy` is due one cycle later, and `rd_data` one cycle after `rd_en`. A program ends after PROG_CYC cycles. A fill ends after PRE_CYC cycles, and the erase ends ERS_CYC cycles after the fill. Once a suspend is captured, `suspended` rises after SUSP_LAT cycles. The bench keeps a free-running cycle count and stamps every write with it. Each pulse is stamped with the cycle in which it is seen, and the stamps are compared with the sums above. It checks `suspended` exactly one cycle before its due cycle and again on it. It samples every output on the falling edge.

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl #(
  parameter int ADDR_W   = 16,
  parameter int SECT_W   = 4,
  parameter int PROG_CYC = 64,
  parameter int PRE_CYC  = 256,
  parameter int ERS_CYC  = 1024,
  parameter int SUSP_LAT = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        arr_data,
  output logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] arr_ra,
  output logic              busy,
  output logic              suspended,
  output logic              arr_wr,
  output logic [ADDR_W-1:0] arr_wa,
  output logic [7:0]        arr_wd,
  output logic              zero_all,
  output logic              erase_all
);

  localparam int MAX_A   = PROG_CYC > PRE_CYC ? PROG_CYC : PRE_CYC;
  localparam int CNT_MAX = MAX_A > ERS_CYC ? MAX_A : ERS_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int WCT_W   = $clog2(SUSP_LAT + 1);
  localparam logic [CNT_W-1:0] LD_PROG = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] LD_PRE  = CNT_W'(PRE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_ERS  = CNT_W'(ERS_CYC - 1);
  localparam logic [WCT_W-1:0] LD_WAIT = WCT_W'(SUSP_LAT - 1);

  localparam logic [11:0] KEY_A1 = 12'h555;
  localparam logic [11:0] KEY_A2 = 12'h2AA;
  localparam logic [7:0]  KEY_D1 = 8'hAA;
  localparam logic [7:0]  KEY_D2 = 8'h55;
  localparam logic [7:0]  OP_PGM = 8'hA0;
  localparam logic [7:0]  OP_SET = 8'h80;
  localparam logic [7:0]  OP_CHP = 8'h10;
  localparam logic [7:0]  OP_HLD = 8'hB0;
  localparam logic [7:0]  OP_RUN = 8'h30;

  typedef enum logic [2:0] {
    M_READ, M_PROG, M_HWAIT, M_HOLD, M_FILL, M_WIPE
  } mode_t;

  typedef enum logic [2:0] {
    K_IDLE, K_U1, K_U2, K_PDATA, K_SET, K_U3, K_U4
  } key_t;

  mode_t             mode;
  key_t              key, key_n;
  logic [CNT_W-1:0]  cnt;
  logic [WCT_W-1:0]  wcnt;
  logic [ADDR_W-1:0] p_addr;
  logic [7:0]        p_data;
  logic              tog;
  logic              go_prog, go_wipe;

  wire hit_a1 = wr_addr[11:0] == KEY_A1;
  wire hit_a2 = wr_addr[11:0] == KEY_A2;
  wire first1 = hit_a1 && wr_data == KEY_D1;
  wire second = hit_a2 && wr_data == KEY_D2;

  always_comb begin
    key_n   = key;
    go_prog = 1'b0;
    go_wipe = 1'b0;
    if (wr_en && mode == M_READ) begin
      unique case (key)
        K_IDLE:  key_n = first1 ? K_U1 : K_IDLE;
        K_U1:    key_n = second ? K_U2 : K_IDLE;
        K_U2: begin
          if (hit_a1 && wr_data == OP_PGM)      key_n = K_PDATA;
          else if (hit_a1 && wr_data == OP_SET) key_n = K_SET;
          else                                  key_n = K_IDLE;
        end
        K_PDATA: begin
          go_prog = 1'b1;
          key_n   = K_IDLE;
        end
        K_SET:   key_n = first1 ? K_U3 : K_IDLE;
        K_U3:    key_n = second ? K_U4 : K_IDLE;
        K_U4: begin
          go_wipe = hit_a1 && wr_data == OP_CHP;
          key_n   = K_IDLE;
        end
        default: key_n = K_IDLE;
      endcase
    end else if (mode != M_READ) begin
      key_n = K_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= M_READ;
      key       <= K_IDLE;
      cnt       <= '0;
      wcnt      <= '0;
      p_addr    <= '0;
      p_data    <= '0;
      arr_wr    <= 1'b0;
      zero_all  <= 1'b0;
      erase_all <= 1'b0;
    end else begin
      key       <= key_n;
      arr_wr    <= 1'b0;
      zero_all  <= 1'b0;
      erase_all <= 1'b0;
      unique case (mode)
        M_READ: begin
          if (go_prog) begin
            mode   <= M_PROG;
            cnt    <= LD_PROG;
            p_addr <= wr_addr;
            p_data <= wr_data;
          end else if (go_wipe) begin
            mode <= M_FILL;
            cnt  <= LD_PRE;
          end
        end
        M_PROG: begin
          if (cnt == '0) begin
            mode   <= M_READ;
            arr_wr <= 1'b1;
          end else if (wr_en && wr_data == OP_HLD) begin
            mode <= M_HWAIT;
            wcnt <= LD_WAIT;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        M_HWAIT: begin
          if (wcnt == '0) mode <= M_HOLD;
          else            wcnt <= wcnt - 1'b1;
        end
        M_HOLD: begin
          if (wr_en && wr_data == OP_RUN) mode <= M_PROG;
        end
        M_FILL: begin
          if (cnt == '0) begin
            mode     <= M_WIPE;
            cnt      <= LD_ERS;
            zero_all <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        M_WIPE: begin
          if (cnt == '0) begin
            mode      <= M_READ;
            erase_all <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: mode <= M_READ;
      endcase
    end
  end

  wire         wiping   = mode == M_FILL || mode == M_WIPE;
  wire [SECT_W-1:0] rd_sect = rd_addr[ADDR_W-1 -: SECT_W];
  wire [SECT_W-1:0] p_sect  = p_addr[ADDR_W-1 -: SECT_W];
  wire         held_hit = mode == M_HOLD && rd_sect == p_sect;
  wire         dq7      = wiping ? 1'b0 : ~p_data[7];
  wire [7:0]   stat     = {dq7, tog, 3'b000, wiping & tog, 2'b00};

  assign busy      = mode == M_PROG || mode == M_HWAIT || wiping;
  assign suspended = mode == M_HOLD;
  assign arr_ra    = rd_addr;
  assign arr_wa    = p_addr;
  assign arr_wd    = p_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      tog     <= 1'b0;
    end else if (rd_en) begin
      if (busy) begin
        rd_data <= stat;
        tog     <= ~tog;
      end else if (held_hit) begin
        rd_data <= {~p_data[7], 7'b0};
      end else begin
        rd_data <= arr_data;
      end
    end
  end

endmodule

// File: rtl/nor_cmd_ctrl_chk.sv
module nor_cmd_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic suspended,
  input logic arr_wr,
  input logic zero_all,
  input logic erase_all
);

  AST_HOLD_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> !busy); // R8

  AST_HOLD_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspended) |-> $past(busy)); // R8

  AST_RESUME_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(suspended) |-> busy); // R10

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arr_wr, zero_all, erase_all})); // R2

  AST_FILL_THEN_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
    zero_all |-> busy); // R2

  AST_WIPE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    erase_all |-> !busy && $past(busy)); // R2

  AST_WRITE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr |-> !busy && !suspended && $past(busy)); // R7

endmodule

bind nor_cmd_ctrl nor_cmd_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .suspended (suspended),
  .arr_wr    (arr_wr),
  .zero_all  (zero_all),
  .erase_all (erase_all)
);

// File: tb/nor_cmd_ctrl_bench.sv
module nor_cmd_ctrl_bench;
  localparam int AW = 16;
  localparam int SW = 4;
  localparam int PG = 16;
  localparam int PR = 20;
  localparam int ER = 30;
  localparam int SL = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    arr_data;
  logic [7:0]    rd_data;
  logic [AW-1:0] arr_ra;
  logic          busy, suspended, arr_wr, zero_all, erase_all;
  logic [AW-1:0] arr_wa;
  logic [7:0]    arr_wd;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int n_zero = 0, n_ers = 0, n_wr = 0, n_hold = 0;
  int t_zero = 0, t_ers = 0, t_wr = 0;
  logic [AW-1:0] got_wa = '0;
  logic [7:0]    got_wd = '0;

  always #4 clk = ~clk;

  assign arr_data = arr_ra[7:0] ^ 8'h5A;

  nor_cmd_ctrl #(
    .ADDR_W(AW), .SECT_W(SW), .PROG_CYC(PG),
    .PRE_CYC(PR), .ERS_CYC(ER), .SUSP_LAT(SL)
  ) u_nor_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .arr_data(arr_data), .rd_data(rd_data), .arr_ra(arr_ra),
    .busy(busy), .suspended(suspended), .arr_wr(arr_wr),
    .arr_wa(arr_wa), .arr_wd(arr_wd), .zero_all(zero_all),
    .erase_all(erase_all)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (zero_all)  begin n_zero++; t_zero = cyc; end
    if (erase_all) begin n_ers++;  t_ers  = cyc; end
    if (arr_wr)    begin n_wr++;   t_wr   = cyc; got_wa = arr_wa; got_wd = arr_wd; end
    if (suspended) n_hold++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    v = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlock;
    wr(16'h0555, 8'hAA);
    wr(16'h02AA, 8'h55);
  endtask

  task automatic erase_seq;
    unlock; wr(16'h0555, 8'h80);
    unlock; wr(16'h0555, 8'h10);
  endtask

  task automatic prog_seq(input logic [AW-1:0] a, input logic [7:0] d);
    unlock; wr(16'h0555, 8'hA0);
    wr(a, d);
  endtask

  task automatic wait_idle;
    while (busy) @(negedge clk);
    idle(2);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    idle(3);
    chk("R1 busy in reset", busy, 0);
    chk("R1 suspended in reset", suspended, 0);
    chk("R1 pulses in reset", {arr_wr, zero_all, erase_all}, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    chk("R1 busy after reset", busy, 0);
    rd(16'h1234, v);
    chk("R11 array read", v, 8'h34 ^ 8'h5A);
    chk("R11 array address", arr_ra, 16'h1234);
  endtask

  task automatic t_erase;
    int z0, e0, st;
    logic [7:0] v1, v2;
    z0 = n_zero; e0 = n_ers;
    erase_seq; st = cyc;
    chk("R2 busy after sixth write", busy, 1);
    rd(16'h0000, v1);
    rd(16'h0000, v2);
    chk("R5 erase dq7", v1[7], 0);
    chk("R5 erase dq6 toggles", v1[6] ^ v2[6], 1);
    chk("R5 erase dq2 follows dq6", v1[2] ^ v1[6], 0);
    chk("R5 erase other bits", (v1 | v2) & 8'h3B, 0);
    wait_idle;
    chk("R2 one fill pulse", n_zero - z0, 1);
    chk("R2 fill time", t_zero, st + PR);
    chk("R2 one erase pulse", n_ers - e0, 1);
    chk("R2 erase time", t_ers, st + PR + ER);
    chk("R2 idle after erase", busy, 0);
    rd(16'h4321, v1);
    chk("R11 array read after erase", v1, 8'h21 ^ 8'h5A);
  endtask

  task automatic t_break;
    int w0;
    w0 = n_wr;
    unlock; wr(16'h0555, 8'h80);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h00);
    wr(16'h0555, 8'h10);
    idle(3);
    chk("R3 wrong data breaks erase", busy, 0);
    wr(16'h0555, 8'hAA); wr(16'h0123, 8'h55);
    wr(16'h0555, 8'hA0); wr(16'h0100, 8'h77);
    idle(PG + 4);
    chk("R3 wrong address breaks program busy", busy, 0);
    chk("R3 wrong address breaks program write", n_wr - w0, 0);
  endtask

  task automatic t_ignore;
    int st, w0, h0;
    w0 = n_wr; h0 = n_hold;
    erase_seq; st = cyc;
    wr(16'h0000, 8'hB0);
    idle(SL + 2);
    chk("R4 suspend ignored during erase", suspended, 0);
    wr(16'h0000, 8'h30);
    prog_seq(16'h0200, 8'h11);
    wait_idle;
    chk("R4 erase time unchanged", t_ers, st + PR + ER);
    chk("R4 no program during erase", n_wr - w0, 0);
    chk("R4 never suspended", n_hold - h0, 0);
  endtask

  task automatic t_hwreset;
    int z0, e0;
    logic [7:0] v;
    z0 = n_zero; e0 = n_ers;
    erase_seq;
    idle(5);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    chk("R6 busy cleared by reset", busy, 0);
    idle(PR + ER + 5);
    chk("R6 no fill after abort", n_zero - z0, 0);
    chk("R6 no erase after abort", n_ers - e0, 0);
    rd(16'h0A0B, v);
    chk("R6 array read after abort", v, 8'h0B ^ 8'h5A);
  endtask

  task automatic t_prog;
    int st, w0;
    logic [7:0] v1, v2;
    w0 = n_wr;
    prog_seq(16'h3456, 8'h5C); st = cyc;
    chk("R7 busy after data write", busy, 1);
    rd(16'h3456, v1);
    rd(16'h3456, v2);
    chk("R5 program dq7", v1[7], 1);
    chk("R5 program dq6 toggles", v1[6] ^ v2[6], 1);
    chk("R5 program dq2", v1[2] | v2[2], 0);
    chk("R5 program other bits", (v1 | v2) & 8'h3B, 0);
    wait_idle;
    chk("R7 one write pulse", n_wr - w0, 1);
    chk("R7 write time", t_wr, st + PG);
    chk("R7 write address", got_wa, 16'h3456);
    chk("R7 write data", got_wd, 8'h5C);
  endtask

  task automatic t_suspend;
    int p0, s0, r0, w0;
    logic [7:0] v;
    w0 = n_wr;
    prog_seq(16'h7010, 8'h25); p0 = cyc;
    idle(3);
    wr(16'h0000, 8'hB0); s0 = cyc;
    chk("R8 busy during settle", busy, 1);
    while (cyc < s0 + SL - 1) @(negedge clk);
    chk("R8 not suspended before settle end", suspended, 0);
    @(negedge clk);
    chk("R8 suspended after settle", suspended, 1);
    chk("R8 not busy when suspended", busy, 0);
    rd(16'h7FF0, v);
    chk("R9 suspended sector blocked", v, 8'h80);
    rd(16'h2033, v);
    chk("R9 other sector readable", v, 8'h33 ^ 8'h5A);
    wr(16'h0555, 8'h55);
    idle(2);
    chk("R10 other write ignored when suspended", suspended, 1);
    chk("R10 no write while suspended", n_wr - w0, 0);
    wr(16'h0000, 8'h30); r0 = cyc;
    chk("R10 busy after resume", busy, 1);
    chk("R10 not suspended after resume", suspended, 0);
    wait_idle;
    chk("R10 one write after resume", n_wr - w0, 1);
    chk("R10 write time after resume", t_wr, r0 + PG - (s0 - p0) + 1);
    chk("R10 write data after resume", got_wd, 8'h25);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset;
    t_erase;
    t_break;
    t_ignore;
    t_hwreset;
    t_prog;
    t_suspend;
    idle(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule